// File: doc/BRIEF.md
# Exception Entry and Return Sequencer

This block owns the processor's current status word and one saved status word for each privileged exception mode. When one or more exception request lines are active, it picks a winner by fixed priority and applies the interrupt masks held in the status word. It then performs the entry sequence. The old status word is banked into the target mode's saved slot. A new status word is formed with the target mode, the interrupts masked and the 32-bit instruction state selected. Fetch is redirected to the vector address, and a link-register write is issued carrying the return address.

A return strobe reverses the sequence for the active mode. The saved word is copied back into the current status word, and fetch is redirected to the link value supplied by the register file. A return from a mode without a saved slot changes nothing and raises an error pulse.

Software-style writes to the current and saved words have the lowest precedence. All outputs are registered, so each effect appears one clock after the cycle in which it was requested.

Top module: `trap_sequencer`

## Requirements
- R1: After reset, `stat_word` is 0x000000D3, which is supervisor mode with I and F set. `saved_word` is 0, and `redirect`, `lr_wr` and `ret_err` are 0.
- R2: An entry redirects to the base address plus four times the vector slot, one cycle after the request. The slots are reset 0, undefined 1, software interrupt 2, prefetch abort 3, data abort 4, IRQ 6 and FIQ 7. The base is 0x00000000, or 0xFFFF0000 when `high_vec` is 1.
- R3: Among simultaneous unmasked requests, the winner is decided in this order: reset, data abort, FIQ, IRQ, prefetch abort, undefined, software interrupt.
- R4: An IRQ request is ignored while bit 7 (I) of the status word is 1. An FIQ request is ignored while bit 6 (F) is 1. An ignored request produces no redirect and leaves the status word unchanged.
- R5: On entry, the previous status word is stored in the target mode's saved slot. It is then visible on `saved_word`.
- R6: On entry, the status word takes the target mode in bits 4:0. The mode codes are user 0x10, FIQ 0x11, IRQ 0x12, supervisor 0x13, abort 0x17, undefined 0x1B and system 0x1F. Reset and software interrupt enter supervisor, both aborts enter abort, undefined enters undefined, and IRQ and FIQ enter their own modes. Bit 7 is set and bits 5 (T) and 24 (J) are cleared. Bit 6 is set only for reset and FIQ, and all other bits are kept.
- R7: Every entry pulses `lr_wr` for one cycle, with `lr_data` = `cur_pc` + 4 and `lr_mode` = the target mode.
- R8: A return from a mode that has a saved slot loads the status word from that slot and redirects to `lr_in`, one cycle later.
- R9: A return from user or system mode (or any unbanked mode code) pulses `ret_err`. It does not redirect and leaves the status word unchanged.
- R10: An entry takes precedence over a return in the same cycle. An entry or return takes precedence over a status or saved-word write in the same cycle, and that write is dropped.
- R11: `stat_wr` replaces the whole status word. `saved_wr` writes the active mode's saved slot. `saved_word` reads 0 in user and system mode, and a `saved_wr` issued there changes no slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_rst | input | 1 | Reset exception request |
| req_und | input | 1 | Undefined instruction request |
| req_swi | input | 1 | Software interrupt request |
| req_pabt | input | 1 | Prefetch abort request |
| req_dabt | input | 1 | Data abort request |
| req_irq | input | 1 | Normal interrupt request |
| req_fiq | input | 1 | Fast interrupt request |
| ret_req | input | 1 | Exception return strobe |
| high_vec | input | 1 | Select the high vector base |
| cur_pc | input | 32 | Address of the current instruction |
| lr_in | input | 32 | Link value of the active mode, used on return |
| stat_wr | input | 1 | Write strobe for the status word |
| stat_wdata | input | 32 | Status word write data |
| saved_wr | input | 1 | Write strobe for the active saved slot |
| saved_wdata | input | 32 | Saved slot write data |
| stat_word | output | 32 | Current status word |
| saved_word | output | 32 | Saved slot of the active mode, or 0 |
| redirect | output | 1 | Fetch redirect pulse |
| redirect_pc | output | 32 | Redirect target |
| lr_wr | output | 1 | Link-register write pulse |
| lr_data | output | 32 | Return address to write |
| lr_mode | output | 5 | Mode whose link register is written |
| ret_err | output | 1 | Return attempted from a mode with no saved slot |

## Verification
The checker runs on every cycle. It confirms that each entry event is followed by a paired redirect and link write, and that the new word carries the target mode, I set and T clear. It also checks that the saved word equals the word held before the entry, that a successful return restores the previous saved word and jumps to the supplied link value, that an error pulse never coincides with a redirect and leaves the word unchanged, and that an FIQ entry only follows a cleared F bit. The bench scenarios are needed for the parts that depend on the stimulus. These are the exact vector address for each exception kind under both bases, the full pairwise priority order, the masking of each interrupt kind with the other one still taken, and which of two colliding commands wins. The bench also shows the saved-slot write isolation between modes.

// File: rtl/trap_pkg.sv
package trap_pkg;
  localparam int SW     = 32;
  localparam int MODE_W = 5;
  localparam int NSLOT  = 8;
  localparam int NBANK  = 5;
  localparam int BIW    = $clog2(NBANK);
  localparam int NPRIO  = 7;

  localparam int BIT_J = 24;
  localparam int BIT_I = 7;
  localparam int BIT_F = 6;
  localparam int BIT_T = 5;

  typedef enum logic [MODE_W-1:0] {
    M_USR = 5'h10, M_FIQ = 5'h11, M_IRQ = 5'h12, M_SVC = 5'h13,
    M_ABT = 5'h17, M_UND = 5'h1B, M_SYS = 5'h1F
  } mode_e;

  // value equals the vector slot number
  typedef enum logic [2:0] {
    X_RST, X_UND, X_SWI, X_PABT, X_DABT, X_RSVD, X_IRQ, X_FIQ
  } slot_e;

  // highest priority first
  localparam slot_e PRIO [0:NPRIO-1] =
    '{X_RST, X_DABT, X_FIQ, X_IRQ, X_PABT, X_UND, X_SWI};

  localparam logic [SW-1:0] RESET_WORD = {{(SW-8){1'b0}}, 8'hD3};

  function automatic logic [MODE_W-1:0] slot_mode(input slot_e s);
    case (s)
      X_UND:          return M_UND;
      X_PABT, X_DABT: return M_ABT;
      X_IRQ:          return M_IRQ;
      X_FIQ:          return M_FIQ;
      default:        return M_SVC;
    endcase
  endfunction

  // {has_slot, slot_index}
  function automatic logic [BIW:0] bank_of(input logic [MODE_W-1:0] m);
    case (m)
      M_FIQ:   return {1'b1, BIW'(0)};
      M_IRQ:   return {1'b1, BIW'(1)};
      M_SVC:   return {1'b1, BIW'(2)};
      M_ABT:   return {1'b1, BIW'(3)};
      M_UND:   return {1'b1, BIW'(4)};
      default: return '0;
    endcase
  endfunction

  function automatic logic [SW-1:0] vector_addr(input logic [SW-1:0] base,
                                                input slot_e s);
    return base + (SW'(s) << 2);
  endfunction

  function automatic logic [SW-1:0] entry_word(input logic [SW-1:0] old,
                                               input slot_e s);
    logic [SW-1:0] w;
    w = old;
    w[BIT_T] = 1'b0;
    w[BIT_J] = 1'b0;
    w[BIT_I] = 1'b1;
    if (s == X_FIQ || s == X_RST) w[BIT_F] = 1'b1;
    w[MODE_W-1:0] = slot_mode(s);
    return w;
  endfunction
endpackage

// File: rtl/trap_arbiter.sv
module trap_arbiter
  import trap_pkg::*;
(
  input  logic [NSLOT-1:0] req,
  input  logic             i_mask,
  input  logic             f_mask,
  output logic             take,
  output slot_e            slot
);
  logic [NSLOT-1:0] eff;

  always_comb begin
    eff = req;
    eff[X_RSVD] = 1'b0;
    eff[X_IRQ]  = req[X_IRQ] & ~i_mask;
    eff[X_FIQ]  = req[X_FIQ] & ~f_mask;
    take = 1'b0;
    slot = X_RST;
    // scan lowest priority first so the highest one overwrites
    for (int p = NPRIO - 1; p >= 0; p--) begin
      if (eff[PRIO[p]]) begin
        take = 1'b1;
        slot = PRIO[p];
      end
    end
  end
endmodule

// File: rtl/saved_bank.sv
module saved_bank
  import trap_pkg::*;
#(
  parameter int DEPTH = NBANK,
  parameter int W     = SW,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [W-1:0]  wr_data,
  input  logic [IW-1:0] rd_idx,
  output logic [W-1:0]  rd_data
);
  logic [W-1:0] arr [DEPTH];

  for (genvar b = 0; b < DEPTH; b++) begin : g_slot
    logic [W-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else if (wr_en && wr_idx == IW'(b)) q <= wr_data;
    end
    assign arr[b] = q;
  end

  always_comb begin
    rd_data = '0;
    for (int b = 0; b < DEPTH; b++)
      if (rd_idx == IW'(b)) rd_data = arr[b];
  end
endmodule

// File: rtl/trap_sequencer.sv
module trap_sequencer
  import trap_pkg::*;
#(
  parameter int            RET_OFS   = 4,
  parameter logic [31:0]   LOW_BASE  = 32'h0000_0000,
  parameter logic [31:0]   HIGH_BASE = 32'hFFFF_0000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_rst,
  input  logic        req_und,
  input  logic        req_swi,
  input  logic        req_pabt,
  input  logic        req_dabt,
  input  logic        req_irq,
  input  logic        req_fiq,
  input  logic        ret_req,
  input  logic        high_vec,
  input  logic [31:0] cur_pc,
  input  logic [31:0] lr_in,
  input  logic        stat_wr,
  input  logic [31:0] stat_wdata,
  input  logic        saved_wr,
  input  logic [31:0] saved_wdata,
  output logic [31:0] stat_word,
  output logic [31:0] saved_word,
  output logic        redirect,
  output logic [31:0] redirect_pc,
  output logic        lr_wr,
  output logic [31:0] lr_data,
  output logic [4:0]  lr_mode
  ,output logic       ret_err
);
  logic [NSLOT-1:0] req_vec;
  logic             take;
  slot_e            win;
  logic [SW-1:0]    stat_q, stat_d;
  logic [BIW:0]     cur_bank, tgt_bank;
  logic [MODE_W-1:0] tgt_mode;
  logic [SW-1:0]    bank_rd, bank_wd;
  logic [BIW-1:0]   bank_widx;
  logic             bank_we;
  logic [SW-1:0]    vec_base;

  // internal events, named for the checker
  logic do_entry, do_ret, ret_ok, ret_bad, do_swr, do_cwr;

  assign req_vec = {req_fiq, req_irq, 1'b0, req_dabt, req_pabt,
                    req_swi, req_und, req_rst};

  trap_arbiter u_arb (
    .req    (req_vec),
    .i_mask (stat_q[BIT_I]),
    .f_mask (stat_q[BIT_F]),
    .take   (take),
    .slot   (win)
  );

  assign cur_bank = bank_of(stat_q[MODE_W-1:0]);
  assign tgt_mode = slot_mode(win);
  assign tgt_bank = bank_of(tgt_mode);

  assign do_entry = take;
  assign do_ret   = ret_req && !take;
  assign ret_ok   = do_ret && cur_bank[BIW];
  assign ret_bad  = do_ret && !cur_bank[BIW];
  assign do_swr   = saved_wr && !take && !do_ret && cur_bank[BIW];
  assign do_cwr   = stat_wr && !take && !do_ret;

  assign bank_we   = do_entry || do_swr;
  assign bank_widx = do_entry ? tgt_bank[BIW-1:0] : cur_bank[BIW-1:0];
  assign bank_wd   = do_entry ? stat_q : saved_wdata;

  saved_bank #(.DEPTH(NBANK), .W(SW)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (bank_we),
    .wr_idx  (bank_widx),
    .wr_data (bank_wd),
    .rd_idx  (cur_bank[BIW-1:0]),
    .rd_data (bank_rd)
  );

  always_comb begin
    stat_d = stat_q;
    if (do_entry)    stat_d = entry_word(stat_q, win);
    else if (ret_ok) stat_d = bank_rd;
    else if (do_cwr) stat_d = stat_wdata;
  end

  assign vec_base = high_vec ? HIGH_BASE : LOW_BASE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q      <= RESET_WORD;
      redirect    <= 1'b0;
      redirect_pc <= '0;
      lr_wr       <= 1'b0;
      lr_data     <= '0;
      lr_mode     <= '0;
      ret_err     <= 1'b0;
    end else begin
      stat_q   <= stat_d;
      redirect <= do_entry || ret_ok;
      lr_wr    <= do_entry;
      ret_err  <= ret_bad;
      if (do_entry) begin
        redirect_pc <= vector_addr(vec_base, win);
        lr_data     <= cur_pc + SW'(RET_OFS);
        lr_mode     <= tgt_mode;
      end else if (ret_ok) begin
        redirect_pc <= lr_in;
      end
    end
  end

  assign stat_word  = stat_q;
  assign saved_word = cur_bank[BIW] ? bank_rd : '0;
endmodule

// File: rtl/trap_sequencer_chk.sv
module trap_sequencer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] stat_word,
  input logic [31:0] saved_word,
  input logic        redirect,
  input logic [31:0] redirect_pc,
  input logic        lr_wr,
  input logic [4:0]  lr_mode,
  input logic        ret_err,
  input logic [31:0] lr_in,
  input logic        do_entry,
  input logic        ret_ok
);
  // R7
  entry_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    do_entry |=> (lr_wr && redirect));

  // R6
  entry_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lr_wr |-> (stat_word[7] && !stat_word[5] && stat_word[4:0] == lr_mode));

  // R5
  bank_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lr_wr |-> (saved_word == $past(stat_word)));

  // R8
  restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ret_ok |=> (redirect && !lr_wr && stat_word == $past(saved_word)
                && redirect_pc == $past(lr_in)));

  // R9
  err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ret_err |-> (!redirect && $stable(stat_word)));

  // R4
  fiq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lr_wr && lr_mode == 5'h11) |-> !$past(stat_word[6]));

  // R2
  vec_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lr_wr |-> (redirect_pc[1:0] == 2'b00 && redirect_pc[4:2] != 3'd5));
endmodule

bind trap_sequencer trap_sequencer_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .stat_word   (stat_word),
  .saved_word  (saved_word),
  .redirect    (redirect),
  .redirect_pc (redirect_pc),
  .lr_wr       (lr_wr),
  .lr_mode     (lr_mode),
  .ret_err     (ret_err),
  .lr_in       (lr_in),
  .do_entry    (do_entry),
  .ret_ok      (ret_ok)
);

// File: tb/tb_trap_sequencer.sv
`timescale 1ns/1ps
module tb_trap_sequencer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [6:0] reqs = '0;   // 0 rst,1 und,2 swi,3 pabt,4 dabt,5 irq,6 fiq
  logic ret_req = 0, high_vec = 0, stat_wr = 0, saved_wr = 0;
  logic [31:0] cur_pc = '0, lr_in = '0, stat_wdata = '0, saved_wdata = '0;
  logic [31:0] stat_word, saved_word, redirect_pc, lr_data;
  logic redirect, lr_wr, ret_err;
  logic [4:0] lr_mode;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  trap_sequencer dut (
    .clk(clk), .rst_n(rst_n),
    .req_rst(reqs[0]), .req_und(reqs[1]), .req_swi(reqs[2]),
    .req_pabt(reqs[3]), .req_dabt(reqs[4]), .req_irq(reqs[5]),
    .req_fiq(reqs[6]), .ret_req(ret_req), .high_vec(high_vec),
    .cur_pc(cur_pc), .lr_in(lr_in), .stat_wr(stat_wr),
    .stat_wdata(stat_wdata), .saved_wr(saved_wr), .saved_wdata(saved_wdata),
    .stat_word(stat_word), .saved_word(saved_word), .redirect(redirect),
    .redirect_pc(redirect_pc), .lr_wr(lr_wr), .lr_data(lr_data),
    .lr_mode(lr_mode), .ret_err(ret_err)
  );

  function automatic logic [4:0] mode_of(input int k);
    case (k)
      1: return 5'h1B;
      3, 4: return 5'h17;
      5: return 5'h12;
      6: return 5'h11;
      default: return 5'h13;
    endcase
  endfunction

  function automatic logic [31:0] vec_of(input int k, input logic hv);
    int s;
    s = (k < 5) ? k : k + 1;
    return (hv ? 32'hFFFF0000 : 32'h0) + 32'(s * 4);
  endfunction

  function automatic logic [31:0] enter(input logic [31:0] w, input int k);
    logic [31:0] r;
    r = w;
    r[4:0] = mode_of(k);
    r[5] = 1'b0;
    r[24] = 1'b0;
    r[7] = 1'b1;
    if (k == 0 || k == 6) r[6] = 1'b1;
    return r;
  endfunction

  function automatic int rank_kind(input int r);
    case (r)
      0: return 0; 1: return 4; 2: return 6; 3: return 5;
      4: return 3; 5: return 1; default: return 2;
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    #1;
  endtask

  task automatic set_stat(input logic [31:0] w);
    stat_wr = 1; stat_wdata = w;
    tick;
    stat_wr = 0;
  endtask

  localparam logic [31:0] W = 32'hF900_0030;  // user, T=1, J=1, flags set

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #5; rst_n = 1'b1;
    #0.5;
    // R1 reset state
    chk("R1 stat", stat_word, 32'h000000D3);
    chk("R1 saved", saved_word, 32'h0);
    chk("R1 outs", {29'b0, redirect, lr_wr, ret_err}, 32'h0);
    tick;

    // R11 whole word write
    set_stat(W);
    chk("R11 stat write", stat_word, W);

    // entry and return sweep over every kind and both bases
    for (int hv = 0; hv < 2; hv++) begin
      for (int k = 0; k < 7; k++) begin
        set_stat(W);
        high_vec = hv[0];
        cur_pc = 32'h1000 + 32'(k * 16);
        reqs = 7'(1 << k);
        tick;
        reqs = '0;
        chk("R2 redirect", {31'b0, redirect}, 32'h1);
        chk("R2 vector", redirect_pc, vec_of(k, hv[0]));
        chk("R7 lr_wr", {31'b0, lr_wr}, 32'h1);
        chk("R7 lr_data", lr_data, 32'h1004 + 32'(k * 16));
        chk("R7 lr_mode", {27'b0, lr_mode}, {27'b0, mode_of(k)});
        chk("R6 stat", stat_word, enter(W, k));
        chk("R5 saved", saved_word, W);
        ret_req = 1; lr_in = 32'hABC0 + 32'(k * 4);
        tick;
        ret_req = 0;
        chk("R8 redirect", {31'b0, redirect, lr_wr}, 32'h2);
        chk("R8 target", redirect_pc, 32'hABC0 + 32'(k * 4));
        chk("R8 stat", stat_word, W);
        tick;
        chk("R8 single pulse", {31'b0, redirect}, 32'h0);
      end
    end
    high_vec = 0;

    // R3 every ordered pair
    for (int a = 0; a < 7; a++) begin
      for (int b = a + 1; b < 7; b++) begin
        set_stat(W);
        reqs = 7'((1 << rank_kind(a)) | (1 << rank_kind(b)));
        tick;
        reqs = '0;
        chk("R3 winner mode", {27'b0, lr_mode}, {27'b0, mode_of(rank_kind(a))});
        chk("R3 winner vector", redirect_pc, vec_of(rank_kind(a), 1'b0));
      end
    end

    // R4 masking
    set_stat(W | 32'h80);
    reqs = 7'b010_0000; tick; reqs = '0;
    chk("R4 irq masked", {31'b0, redirect}, 32'h0);
    chk("R4 irq masked stat", stat_word, W | 32'h80);
    reqs = 7'b010_1000; tick; reqs = '0;
    chk("R4 pabt past masked irq", {27'b0, lr_mode}, 32'h17);
    set_stat(W | 32'h40);
    reqs = 7'b100_0000; tick; reqs = '0;
    chk("R4 fiq masked", {31'b0, redirect}, 32'h0);
    chk("R4 fiq masked stat", stat_word, W | 32'h40);
    reqs = 7'b110_0000; tick; reqs = '0;
    chk("R4 irq past masked fiq", {27'b0, lr_mode}, 32'h12);

    // R9 return without a saved slot
    set_stat(W);
    ret_req = 1; lr_in = 32'h5555; tick; ret_req = 0;
    chk("R9 user err", {30'b0, ret_err, redirect}, 32'h2);
    chk("R9 user stat", stat_word, W);
    set_stat(32'h6000_001F);
    ret_req = 1; tick; ret_req = 0;
    chk("R9 system err", {30'b0, ret_err, redirect}, 32'h2);
    chk("R9 system stat", stat_word, 32'h6000_001F);

    // R10 collisions
    set_stat(W);
    reqs = 7'b000_0100; ret_req = 1; stat_wr = 1; stat_wdata = 32'h0;
    tick;
    reqs = '0; ret_req = 0; stat_wr = 0;
    chk("R10 entry wins", {27'b0, lr_mode}, 32'h13);
    chk("R10 no err", {31'b0, ret_err}, 32'h0);
    chk("R10 entry stat", stat_word, enter(W, 2));
    ret_req = 1; lr_in = 32'h7770; stat_wr = 1; stat_wdata = 32'h12;
    tick;
    ret_req = 0; stat_wr = 0;
    chk("R10 return wins stat", stat_word, W);
    chk("R10 return redirect", redirect_pc, 32'h7770);

    // R11 saved slot writes
    set_stat(32'h0000_0012);
    saved_wr = 1; saved_wdata = 32'h1234_5678; tick; saved_wr = 0;
    chk("R11 saved write", saved_word, 32'h1234_5678);
    set_stat(32'h0000_0010);
    chk("R11 user reads zero", saved_word, 32'h0);
    saved_wr = 1; saved_wdata = 32'hDEAD_BEEF; tick; saved_wr = 0;
    set_stat(32'h0000_0012);
    chk("R11 user write ignored", saved_word, 32'h1234_5678);
    set_stat(32'h0000_0013);
    chk("R11 other slot", saved_word, W);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule